// File: doc/BRIEF.md
# Receive IPv4 Checksum Offload Checker

This block sits beside a receive MAC datapath and watches each incoming Ethernet frame as a byte stream with start, end and valid strobes. It locates the IPv4 header behind at most one VLAN tag and either a plain EtherType or an LLC/SNAP header. It runs the frame through a chain of qualification tests. When the frame qualifies, it verifies the IP header checksum and, for unfragmented TCP or UDP packets, the transport checksum including the pseudo-header.

At the end of each frame the block emits a one-cycle result: a 2-bit status field, a SNAP indication, a drop request, and one-cycle increment pulses for an IP-header error counter and a transport error counter. When checking is switched off, the status field carries the caller's type-match bits unchanged instead.

Top module: `rxck_top`

## Requirements
- R1: The result (`res_valid` and every result output) appears in the clock cycle after the byte carrying `in_eof` is accepted. It lasts exactly one cycle and is low while a frame is still streaming.
- R2: A frame qualifies only if it meets all of the following. The EtherType is 0x0800. The first IP byte has version 4 in its upper nibble and a header length (IHL, lower nibble, in 32-bit words) of at least 5. The IP total length (IP bytes 2..3) is at least IHL*4. Any other frame reports status 00 with no drop.
- R3: The IP header checksum passes when the 16-bit one's-complement sum of all IHL*4 header bytes, taken as big-endian words, equals 0xFFFF. A failure reports status 00, raises `drop_req` and pulses `err_ip_inc`.
- R4: Transport checking covers protocol 6 (TCP) and protocol 17 (UDP). The sum runs over a pseudo-header and then over total-length minus IHL*4 segment bytes. The pseudo-header is the source and destination addresses (IP bytes 12..19), a zero byte with the protocol byte, and the segment length. A sum of 0xFFFF reports status 10 for TCP or 11 for UDP, with no drop.
- R5: A transport sum other than 0xFFFF reports status 01, raises `drop_req` and pulses `err_l4_inc`. The two error pulses are never high together.
- R6: An odd-length segment has its last byte summed as the high byte of a word whose low byte is zero.
- R7: Some frames report status 01 (IP header verified only) with no drop. This covers a fragmented packet, with the more-fragments flag (bit 5 of IP byte 6) set or a non-zero 13-bit fragment offset. It also covers any protocol other than TCP or UDP.
- R8: EtherType 0x8100 introduces one four-byte VLAN tag. Its CFI bit (bit 4 of the first tag byte) must be 0; a set CFI bit reports status 00 with no drop.
- R9: A type/length value below 0x0600 must be followed by the six bytes AA AA 03 00 00 00 and then EtherType 0x0800. Such a frame is checked and reports `res_snap` = 1. Any mismatch in those six bytes reports status 00 and `res_snap` = 0.
- R10: With `csum_en` low at the end-of-frame byte, `res_field` equals `type_match` sampled on that byte. In that case `res_snap`, `drop_req` and both error pulses stay low.
- R11: Bytes beyond the segment length (padding, FCS) do not affect the result. A frame that ends before its segment is complete reports status 01 with no drop.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| csum_en | input | 1 | Checksum checking enabled (sampled on the last byte) |
| type_match | input | 2 | Type-match bits passed through when checking is off |
| res_valid | output | 1 | One-cycle per-frame result strobe |
| res_field | output | 2 | Status code or passed-through type-match bits |
| res_snap | output | 1 | Frame used LLC/SNAP encapsulation |
| drop_req | output | 1 | Frame should be discarded |
| err_ip_inc | output | 1 | Increment for the IP header checksum error counter |
| err_l4_inc | output | 1 | Increment for the transport checksum error counter |

## Verification
Every result output is registered on the clock edge that accepts the end-of-frame byte. The bench therefore drives bytes on falling edges and reads all result outputs at the falling edge right after that accepting edge. It reads them again one falling edge later to confirm that the strobe, drop request and error pulses have all returned low. In the middle of every frame it also confirms that no result strobe is pending. Reset outputs are read at a falling edge before the first frame.

// File: rtl/rxck_pkg.sv
package rxck_pkg;
    localparam int LEN_W = 16;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_MAC, ST_TYPE, ST_VTAG, ST_LLC, ST_IP, ST_L4, ST_WAIT
    } pst_e;

    localparam logic [WORD_W-1:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [WORD_W-1:0] ETYPE_VLAN = 16'h8100;
    localparam logic [WORD_W-1:0] LEN_LIMIT  = 16'h0600;
    localparam logic [7:0] PROTO_TCP = 8'd6;
    localparam logic [7:0] PROTO_UDP = 8'd17;

    localparam logic [LEN_W-1:0] ONE        = 1;
    localparam logic [LEN_W-1:0] MAC_LAST   = 11;
    localparam logic [LEN_W-1:0] LLC_LAST   = 5;
    localparam logic [LEN_W-1:0] OFF_TLEN   = 3;
    localparam logic [LEN_W-1:0] OFF_FRAG_H = 6;
    localparam logic [LEN_W-1:0] OFF_FRAG_L = 7;
    localparam logic [LEN_W-1:0] OFF_PROTO  = 9;
    localparam logic [LEN_W-1:0] OFF_CSUM_L = 11;
    localparam logic [LEN_W-1:0] OFF_ADDR_A = 13;
    localparam logic [LEN_W-1:0] OFF_ADDR_Z = 19;

    localparam logic [1:0] CODE_NONE = 2'b00;
    localparam logic [1:0] CODE_IP   = 2'b01;
    localparam logic [1:0] CODE_TCP  = 2'b10;
    localparam logic [1:0] CODE_UDP  = 2'b11;

    typedef struct packed {
        pst_e             st;
        logic [LEN_W-1:0] idx;
        logic [7:0]       hi;
        logic             vlan;
        logic             snap;
        logic [3:0]       ihl;
        logic [LEN_W-1:0] tot;
        logic [7:0]       proto;
        logic             frag;
        logic             ip_done;
        logic             ip_ok;
        logic             l4_elig;
        logic             l4_done;
        logic             l4_ok;
        logic [LEN_W-1:0] l4len;
        logic             res_valid;
        logic [1:0]       res_field;
        logic             res_snap;
        logic             drop;
        logic             err_ip;
        logic             err_l4;
    } rxck_state_t;

    function automatic logic [7:0] llc_expect(input logic [LEN_W-1:0] i);
        if (i < 2) return 8'hAA;
        if (i == 2) return 8'h03;
        return 8'h00;
    endfunction
endpackage

// File: rtl/rxck_csum_acc.sv
module rxck_csum_acc #(
    parameter int W    = 16,
    parameter int N_IN = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [N_IN-1:0]         add_en,
    input  logic [N_IN-1:0][W-1:0]  add_word,
    output logic [W-1:0]            sum_q,
    output logic [W-1:0]            sum_d
);
    always_comb begin
        logic [W-1:0] acc;
        logic [W:0]   raw;
        acc = clr ? '0 : sum_q;
        raw = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (add_en[i]) begin
                raw = {1'b0, acc} + {1'b0, add_word[i]};
                acc = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
            end
        end
        sum_d = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end
endmodule

// File: rtl/rxck_verdict.sv
module rxck_verdict (
    input  logic       en,
    input  logic       ip_done,
    input  logic       ip_ok,
    input  logic       l4_elig,
    input  logic       l4_done,
    input  logic       l4_ok,
    input  logic       is_udp,
    input  logic       snap,
    input  logic [1:0] type_match,
    output logic [1:0] field,
    output logic       snap_o,
    output logic       drop,
    output logic       err_ip,
    output logic       err_l4
);
    import rxck_pkg::*;
    logic [1:0] code;
    logic       ip_bad, l4_bad;

    always_comb begin
        ip_bad = ip_done && !ip_ok;
        l4_bad = ip_done && ip_ok && l4_elig && l4_done && !l4_ok;
        if (!ip_done || !ip_ok)                code = CODE_NONE;
        else if (l4_elig && l4_done && l4_ok)  code = is_udp ? CODE_UDP : CODE_TCP;
        else                                   code = CODE_IP;
        field  = en ? code : type_match;
        snap_o = en && snap;
        drop   = en && (ip_bad || l4_bad);
        err_ip = en && ip_bad;
        err_l4 = en && l4_bad;
    end
endmodule

// File: rtl/rxck_top.sv
module rxck_top
    import rxck_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    input  logic       csum_en,
    input  logic [1:0] type_match,
    output logic       res_valid,
    output logic [1:0] res_field,
    output logic       res_snap,
    output logic       drop_req,
    output logic       err_ip_inc,
    output logic       err_l4_inc
);
    rxck_state_t q, p_d, d;

    logic                         take;
    logic [LEN_W-1:0]             hlen, hlast;
    logic [0:0]                   ip_en;
    logic [0:0][WORD_W-1:0]       ip_word;
    logic [1:0]                   l4_en;
    logic [1:0][WORD_W-1:0]       l4_word;
    logic [WORD_W-1:0]            ip_sum_q, ip_sum_d, l4_sum_q, l4_sum_d;
    logic [WORD_W-1:0]            etype;
    logic [1:0]                   v_field;
    logic                         v_snap, v_drop, v_eip, v_el4;

    // accumulator feeds
    always_comb begin
        take       = in_valid && !in_sof;
        hlen       = {{(LEN_W-6){1'b0}}, q.ihl, 2'b00};
        hlast      = hlen - ONE;
        ip_en[0]   = take && (q.st == ST_IP) && q.idx[0];
        ip_word[0] = {q.hi, in_data};
        l4_en      = '0;
        l4_word    = '0;
        if (take && q.st == ST_IP) begin
            if (q.idx[0] && q.idx >= OFF_ADDR_A && q.idx <= OFF_ADDR_Z) begin
                l4_en[0]   = 1'b1;
                l4_word[0] = {q.hi, in_data};
            end else if (q.idx == OFF_CSUM_L) begin
                l4_en[0]   = 1'b1;
                l4_word[0] = {8'h00, q.proto};
            end
            if (q.idx == hlast) begin
                l4_en[1]   = 1'b1;
                l4_word[1] = q.tot - hlen;
            end
        end else if (take && q.st == ST_L4) begin
            if (q.idx[0]) begin
                l4_en[0]   = 1'b1;
                l4_word[0] = {q.hi, in_data};
            end else if (q.idx == q.l4len - ONE) begin
                l4_en[0]   = 1'b1;
                l4_word[0] = {in_data, 8'h00};
            end
        end
    end

    rxck_csum_acc #(.W(WORD_W), .N_IN(1)) ip_acc_i (
        .clk(clk), .rst_n(rst_n), .clr(in_valid && in_sof),
        .add_en(ip_en), .add_word(ip_word), .sum_q(ip_sum_q), .sum_d(ip_sum_d)
    );

    rxck_csum_acc #(.W(WORD_W), .N_IN(2)) l4_acc_i (
        .clk(clk), .rst_n(rst_n), .clr(in_valid && in_sof),
        .add_en(l4_en), .add_word(l4_word), .sum_q(l4_sum_q), .sum_d(l4_sum_d)
    );

    // header walk
    always_comb begin
        p_d           = q;
        p_d.res_valid = 1'b0;
        p_d.drop      = 1'b0;
        p_d.err_ip    = 1'b0;
        p_d.err_l4    = 1'b0;
        etype         = {q.hi, in_data};
        if (in_valid) begin
            p_d.hi = in_data;
            if (in_sof) begin
                p_d.st      = ST_MAC;
                p_d.idx     = ONE;
                p_d.vlan    = 1'b0;
                p_d.snap    = 1'b0;
                p_d.ihl     = 4'd5;
                p_d.tot     = '0;
                p_d.proto   = '0;
                p_d.frag    = 1'b0;
                p_d.ip_done = 1'b0;
                p_d.ip_ok   = 1'b0;
                p_d.l4_elig = 1'b0;
                p_d.l4_done = 1'b0;
                p_d.l4_ok   = 1'b0;
                p_d.l4len   = '0;
            end else begin
                unique case (q.st)
                    ST_MAC: begin
                        if (q.idx == MAC_LAST) begin p_d.st = ST_TYPE; p_d.idx = '0; end
                        else p_d.idx = q.idx + ONE;
                    end
                    ST_TYPE: begin
                        if (q.idx == '0) p_d.idx = ONE;
                        else begin
                            p_d.idx = '0;
                            if (etype == ETYPE_VLAN && !q.vlan && !q.snap) begin
                                p_d.st = ST_VTAG; p_d.vlan = 1'b1;
                            end else if (etype == ETYPE_IPV4) p_d.st = ST_IP;
                            else if (etype < LEN_LIMIT && !q.snap) p_d.st = ST_LLC;
                            else p_d.st = ST_WAIT;
                        end
                    end
                    ST_VTAG: begin
                        if (q.idx == '0) begin
                            p_d.idx = ONE;
                            if (in_data[4]) p_d.st = ST_WAIT;
                        end else begin
                            p_d.st = ST_TYPE; p_d.idx = '0;
                        end
                    end
                    ST_LLC: begin
                        if (in_data != llc_expect(q.idx)) p_d.st = ST_WAIT;
                        else if (q.idx == LLC_LAST) begin
                            p_d.st = ST_TYPE; p_d.idx = '0; p_d.snap = 1'b1;
                        end else p_d.idx = q.idx + ONE;
                    end
                    ST_IP: begin
                        if (q.idx == '0) begin
                            if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) p_d.st = ST_WAIT;
                            else p_d.ihl = in_data[3:0];
                        end
                        if (q.idx == OFF_TLEN)   p_d.tot = {q.hi, in_data};
                        if (q.idx == OFF_FRAG_H) p_d.frag = in_data[5] || (in_data[4:0] != '0);
                        if (q.idx == OFF_FRAG_L) p_d.frag = q.frag || (in_data != '0);
                        if (q.idx == OFF_PROTO)  p_d.proto = in_data;
                        if (q.idx == hlast) begin
                            p_d.idx     = '0;
                            p_d.ip_done = (q.tot >= hlen);
                            p_d.ip_ok   = (ip_sum_d == '1);
                            p_d.l4len   = q.tot - hlen;
                            p_d.l4_elig = p_d.ip_done && p_d.ip_ok && !q.frag
                                          && (q.proto == PROTO_TCP || q.proto == PROTO_UDP)
                                          && (p_d.l4len != '0);
                            p_d.st      = p_d.l4_elig ? ST_L4 : ST_WAIT;
                        end else if (q.idx != '0 || p_d.st == ST_IP) begin
                            p_d.idx = q.idx + ONE;
                        end
                    end
                    ST_L4: begin
                        if (q.idx == q.l4len - ONE) begin
                            p_d.st      = ST_WAIT;
                            p_d.l4_done = 1'b1;
                            p_d.l4_ok   = (l4_sum_d == '1);
                        end else p_d.idx = q.idx + ONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    rxck_verdict verdict_i (
        .en(csum_en), .ip_done(p_d.ip_done), .ip_ok(p_d.ip_ok),
        .l4_elig(p_d.l4_elig), .l4_done(p_d.l4_done), .l4_ok(p_d.l4_ok),
        .is_udp(p_d.proto == PROTO_UDP), .snap(p_d.snap), .type_match(type_match),
        .field(v_field), .snap_o(v_snap), .drop(v_drop), .err_ip(v_eip), .err_l4(v_el4)
    );

    // end-of-frame result capture
    always_comb begin
        d = p_d;
        if (in_valid && in_eof) begin
            d.st        = ST_IDLE;
            d.res_valid = 1'b1;
            d.res_field = v_field;
            d.res_snap  = v_snap;
            d.drop      = v_drop;
            d.err_ip    = v_eip;
            d.err_l4    = v_el4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid  = q.res_valid;
    assign res_field  = q.res_valid ? q.res_field : 2'b00;
    assign res_snap   = q.res_valid && q.res_snap;
    assign drop_req   = q.drop;
    assign err_ip_inc = q.err_ip;
    assign err_l4_inc = q.err_l4;
endmodule

// File: rtl/rxck_top_chk.sv
module rxck_top_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input logic       in_eof,
    input logic [7:0] in_data,
    input logic       csum_en,
    input logic [1:0] type_match,
    input logic       res_valid,
    input logic [1:0] res_field,
    input logic       res_snap,
    input logic       drop_req,
    input logic       err_ip_inc,
    input logic       err_l4_inc
);
    assert_result_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> res_valid);

    assert_result_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_eof));

    assert_drop_with_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_req |-> res_valid);

    assert_ip_err_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_ip_inc |-> (res_field == 2'b00 && drop_req));

    assert_good_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_field[1]) |-> !drop_req);

    assert_err_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_ip_inc, err_l4_inc}));

    assert_l4_err_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_l4_inc |-> (res_field == 2'b01 && drop_req));

    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && !csum_en) |=>
            (!drop_req && !res_snap && res_field == $past(type_match)));
endmodule

bind rxck_top rxck_top_chk chk_i (.*);

// File: tb/rxck_top_tb_top.sv
`timescale 1ns/1ps
module rxck_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sof, in_eof, csum_en;
    logic [7:0] in_data;
    logic [1:0] type_match;
    logic       res_valid, res_snap, drop_req, err_ip_inc, err_l4_inc;
    logic [1:0] res_field;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] fr [0:127];
    int flen, ip_off, l4_off;

    always #4 clk = ~clk;

    rxck_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .csum_en(csum_en),
        .type_match(type_match), .res_valid(res_valid), .res_field(res_field),
        .res_snap(res_snap), .drop_req(drop_req), .err_ip_inc(err_ip_inc),
        .err_l4_inc(err_l4_inc)
    );

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

    task automatic put(inout int p, input logic [7:0] b);
        fr[p] = b;
        p = p + 1;
    endtask

    task automatic build(input bit vl, input bit cfi, input bit sn, input int ihl,
                         input logic [7:0] proto, input int plen, input bit mf,
                         input logic [12:0] foff, input int tail);
        int p;
        int hl;
        int tot;
        int cs;
        logic [15:0] s;
        p = 0;
        for (int i = 0; i < 12; i++) put(p, 8'(8'h10 + i));
        if (vl) begin
            put(p, 8'h81); put(p, 8'h00); put(p, {3'b000, cfi, 4'h0}); put(p, 8'h05);
        end
        if (sn) begin
            put(p, 8'h00); put(p, 8'h40);
            put(p, 8'hAA); put(p, 8'hAA); put(p, 8'h03);
            put(p, 8'h00); put(p, 8'h00); put(p, 8'h00);
        end
        put(p, 8'h08); put(p, 8'h00);
        ip_off = p;
        hl  = ihl * 4;
        tot = hl + plen;
        for (int i = 0; i < hl; i++) fr[ip_off + i] = 8'h00;
        fr[ip_off + 0] = {4'h4, 4'(ihl)};
        fr[ip_off + 2] = 8'(tot >> 8);
        fr[ip_off + 3] = 8'(tot);
        fr[ip_off + 4] = 8'h12;
        fr[ip_off + 5] = 8'h34;
        fr[ip_off + 6] = {2'b00, mf, foff[12:8]};
        fr[ip_off + 7] = foff[7:0];
        fr[ip_off + 8] = 8'h40;
        fr[ip_off + 9] = proto;
        fr[ip_off + 12] = 8'hC0; fr[ip_off + 13] = 8'hA8;
        fr[ip_off + 14] = 8'h01; fr[ip_off + 15] = 8'h0A;
        fr[ip_off + 16] = 8'hC0; fr[ip_off + 17] = 8'hA8;
        fr[ip_off + 18] = 8'h01; fr[ip_off + 19] = 8'h14;
        s = 16'h0;
        for (int i = 0; i < hl; i += 2) s = oc_add(s, {fr[ip_off + i], fr[ip_off + i + 1]});
        fr[ip_off + 10] = ~s[15:8];
        fr[ip_off + 11] = ~s[7:0];
        l4_off = ip_off + hl;
        for (int i = 0; i < plen; i++) fr[l4_off + i] = 8'(i * 7 + 1);
        if (proto == 8'd6 || proto == 8'd17) begin
            cs = (proto == 8'd6) ? 16 : 6;
            fr[l4_off + cs] = 8'h00;
            fr[l4_off + cs + 1] = 8'h00;
            if (proto == 8'd17) begin
                fr[l4_off + 4] = 8'(plen >> 8);
                fr[l4_off + 5] = 8'(plen);
            end
            s = 16'h0;
            for (int i = 12; i < 20; i += 2) s = oc_add(s, {fr[ip_off + i], fr[ip_off + i + 1]});
            s = oc_add(s, {8'h00, proto});
            s = oc_add(s, 16'(plen));
            for (int i = 0; i < plen; i += 2)
                s = oc_add(s, {fr[l4_off + i], (i + 1 < plen) ? fr[l4_off + i + 1] : 8'h00});
            fr[l4_off + cs] = ~s[15:8];
            fr[l4_off + cs + 1] = ~s[7:0];
        end
        flen = l4_off + plen;
        for (int t = 0; t < tail; t++) begin
            fr[flen] = 8'(8'hE0 + t);
            flen = flen + 1;
        end
    endtask

    task automatic send(input logic en, input logic [1:0] tm);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            if (i == flen / 2) begin
                n_vec++;
                if (res_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R1 mid-frame strobe: got %b expected 0", res_valid);
                end
            end
            in_valid   = 1'b1;
            in_sof     = (i == 0);
            in_eof     = (i == flen - 1);
            in_data    = fr[i];
            csum_en    = en;
            type_match = tm;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    // called at the falling edge right after the last byte was accepted
    task automatic expect_res(input string req, input logic [1:0] f, input logic sn,
                              input logic dr, input logic ei, input logic el);
        logic [6:0] act, exp;
        act = {res_valid, res_field, res_snap, drop_req, err_ip_inc, err_l4_inc};
        exp = {1'b1, f, sn, dr, ei, el};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {valid,field,snap,drop,eip,el4} got %b expected %b", req, act, exp);
        end
        @(negedge clk);
        act = {res_valid, res_field, res_snap, drop_req, err_ip_inc, err_l4_inc};
        n_vec++;
        if (act !== 7'b0) begin
            n_bad++;
            $display("FAIL R1 pulse after %s: got %b expected %b", req, act, 7'b0);
        end
    endtask

    task automatic t_reset;
        n_vec++;
        if ({res_valid, res_field, res_snap, drop_req, err_ip_inc, err_l4_inc} !== 7'b0) begin
            n_bad++;
            $display("FAIL R12 reset outputs: got %b expected %b",
                     {res_valid, res_field, res_snap, drop_req, err_ip_inc, err_l4_inc}, 7'b0);
        end
    endtask

    task automatic t_good;
        build(0, 0, 0, 5, 8'd6, 40, 0, 13'd0, 4);
        send(1'b1, 2'b00); expect_res("R4 TCP even with tail (R11)", 2'b10, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd17, 21, 0, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R6 UDP odd length", 2'b11, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd6, 33, 0, 13'd0, 4);
        send(1'b1, 2'b00); expect_res("R6 TCP odd length", 2'b10, 0, 0, 0, 0);
    endtask

    task automatic t_bad_sums;
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'd0, 0);
        fr[ip_off + 8] = fr[ip_off + 8] ^ 8'h01;
        send(1'b1, 2'b00); expect_res("R3 bad IP header sum", 2'b00, 0, 1, 1, 0);
        build(0, 0, 0, 5, 8'd17, 20, 0, 13'd0, 0);
        fr[l4_off + 12] = fr[l4_off + 12] ^ 8'h40;
        send(1'b1, 2'b00); expect_res("R5 bad UDP sum", 2'b01, 0, 1, 0, 1);
        build(0, 0, 0, 5, 8'd17, 21, 0, 13'd0, 0);
        fr[l4_off + 20] = fr[l4_off + 20] ^ 8'h80;
        send(1'b1, 2'b00); expect_res("R6 odd last byte counted high", 2'b01, 0, 1, 0, 1);
    endtask

    task automatic t_not_eligible;
        build(0, 0, 0, 5, 8'd6, 24, 1, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R7 more-fragments", 2'b01, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'h010, 0);
        send(1'b1, 2'b00); expect_res("R7 fragment offset", 2'b01, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd1, 12, 0, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R7 other protocol", 2'b01, 0, 0, 0, 0);
    endtask

    task automatic t_vlan;
        build(1, 0, 0, 5, 8'd17, 16, 0, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R8 VLAN CFI clear", 2'b11, 0, 0, 0, 0);
        build(1, 1, 0, 5, 8'd17, 16, 0, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R8 VLAN CFI set", 2'b00, 0, 0, 0, 0);
    endtask

    task automatic t_snap;
        build(0, 0, 1, 5, 8'd6, 26, 0, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R9 SNAP TCP", 2'b10, 1, 0, 0, 0);
        build(1, 0, 1, 5, 8'd17, 11, 0, 13'd0, 4);
        send(1'b1, 2'b00); expect_res("R9 VLAN plus SNAP UDP", 2'b11, 1, 0, 0, 0);
        build(0, 0, 1, 5, 8'd6, 26, 0, 13'd0, 0);
        fr[16] = 8'h02;
        send(1'b1, 2'b00); expect_res("R9 bad LLC byte", 2'b00, 0, 0, 0, 0);
    endtask

    task automatic t_qualify;
        build(0, 0, 0, 6, 8'd6, 28, 0, 13'd0, 0);
        send(1'b1, 2'b00); expect_res("R2 IHL 6 with option", 2'b10, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'd0, 0);
        fr[ip_off] = 8'h44;
        send(1'b1, 2'b00); expect_res("R2 IHL 4", 2'b00, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'd0, 0);
        fr[ip_off] = 8'h65;
        send(1'b1, 2'b00); expect_res("R2 version 6", 2'b00, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'd0, 0);
        fr[ip_off - 1] = 8'h06;
        send(1'b1, 2'b00); expect_res("R2 EtherType 0x0806", 2'b00, 0, 0, 0, 0);
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'd0, 0);
        fr[ip_off + 2] = 8'h00;
        fr[ip_off + 3] = 8'h10;
        send(1'b1, 2'b00); expect_res("R2 total length below header", 2'b00, 0, 0, 0, 0);
    endtask

    task automatic t_bypass;
        build(0, 0, 0, 5, 8'd6, 24, 0, 13'd0, 0);
        fr[ip_off + 8] = fr[ip_off + 8] ^ 8'h01;
        send(1'b0, 2'b10); expect_res("R10 disabled with bad sum", 2'b10, 0, 0, 0, 0);
        build(0, 0, 1, 5, 8'd6, 24, 0, 13'd0, 0);
        send(1'b0, 2'b01); expect_res("R10 disabled SNAP", 2'b01, 0, 0, 0, 0);
    endtask

    task automatic t_trunc;
        build(0, 0, 0, 5, 8'd6, 30, 0, 13'd0, 0);
        flen = l4_off + 10;
        send(1'b1, 2'b00); expect_res("R11 truncated segment", 2'b01, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data = 8'h00; csum_en = 1'b0; type_match = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_bad_sums();
        t_not_eligible();
        t_vlan();
        t_snap();
        t_qualify();
        t_bypass();
        t_trunc();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule